// File: doc/BRIEF.md
# PWM Fault Condition Generator

This unit decides, for one PWM generator, whether the generator must stop driving its normal waveform. It watches four external fault pins, a debug-stall indication and eight analog-comparator trigger lines. Each pin first passes through a two-flop synchronizer. Its active level is then corrected by a per-pin polarity bit. Each source is gated by its own enable bit, and all enabled sources are ORed into a single raw fault condition.

The raw condition can be stretched by a down-counter, so that any fault lasts for a programmed minimum number of cycles. In follow mode the resulting fault simply tracks its inputs. In latched mode the fault is held until software writes a clear, and that clear only takes effect once the condition has gone away. While the fault is active, both PWM outputs are replaced by programmable safe levels. An interrupt request can be raised for the fault. Sticky, write-one-to-clear status bits record which pins and which comparator lines contributed.

Software configures the unit through a single-cycle write port. The map has five words. CFG (address 0) holds the following bits: bit 0 latch mode, bit 1 stretch enable, bit 2 stall enable, bit 3 interrupt enable, bit 4 safe level for output A, bit 5 safe level for output B. PINS (address 1) holds the pin enables in bits [3:0] and the pin polarities in bits [11:8], where 1 means active-low. CMP (address 2) holds the comparator enables in bits [7:0]. MINPER (address 3) holds the 16-bit minimum period in bits [15:0]. CLR (address 4) is write-only. Writing 1 to bits [3:0] clears pin status, writing 1 to bits [15:8] clears comparator status, and writing 1 to bit 16 clears the latched fault.

Top module: `pwm_fault_unit`

## Requirements
- R1: A fault pin change reaches the fault output exactly two clock edges after it is applied, through a two-flop synchronizer.
- R2: A pin whose polarity bit (PINS bit 8+i) is 1 is active when low, and a pin whose polarity bit is 0 is active when high.
- R3: A pin, comparator line or debug stall causes a fault only when its enable bit is set (PINS bits [3:0], CMP bits [7:0], CFG bit 2). Comparator and stall inputs act in the same cycle they are applied.
- R4: With latch mode (CFG bit 0) and stretch (CFG bit 1) both off, the fault output equals the OR of the enabled, polarity-corrected sources.
- R5: In latched mode the fault stays active after the sources go inactive, until a write of 1 to CLR bit 16. A clear written while the condition is still present has no effect.
- R6: With stretch enabled, a 16-bit counter reloads from MINPER on every cycle a source is active. The fault stays active for MINPER further cycles after the sources drop.
- R7: With stretch disabled, the fault ends in the same cycle the sources drop, whatever the value of MINPER.
- R8: Status bits are set one cycle after their source contributes and stay set until written with 1 at CLR. A contribution in the same cycle as a clear keeps the bit set.
- R9: irq_o is high exactly when the fault is active and CFG bit 3 is set.
- R10: While the fault is active, pwm_a_o and pwm_b_o equal CFG bits 4 and 5. Otherwise they pass pwm_a_i and pwm_b_i through unchanged.
- R11: After reset, all configuration and status is zero, no fault is active, and the PWM inputs pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| fault_pin_i | input | 4 | External fault pins, asynchronous |
| dbg_stall_i | input | 1 | Debug stall indication |
| cmp_trig_i | input | 8 | Comparator trigger lines |
| pwm_a_i | input | 1 | Normal waveform for output A |
| pwm_b_i | input | 1 | Normal waveform for output B |
| pwm_a_o | output | 1 | Conditioned output A |
| pwm_b_o | output | 1 | Conditioned output B |
| fault_o | output | 1 | Active fault condition |
| irq_o | output | 1 | Fault interrupt request |
| pin_stat_o | output | 4 | Sticky per-pin fault status |
| cmp_stat_o | output | 8 | Sticky per-comparator fault status |

## Verification
The bench builds the unit with its default parameters: four pins, eight comparator lines and a 16-bit counter. With these widths every register bit in the map above is real, so each pin polarity and each source enable can be flipped one at a time. MINPER is programmed to small values such as 3, which keeps the stretched tail to a few cycles. That makes it practical to count the tail cycle by cycle, and to probe clears and status writes at the exact cycle a source is asserted.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int REG_CFG    = 0;
  localparam int REG_PINS   = 1;
  localparam int REG_CMP    = 2;
  localparam int REG_MINPER = 3;
  localparam int REG_CLR    = 4;

  localparam int CFG_LATCH   = 0;
  localparam int CFG_STRETCH = 1;
  localparam int CFG_STALL   = 2;
  localparam int CFG_IRQ     = 3;
  localparam int CFG_SAFE_A  = 4;
  localparam int CFG_SAFE_B  = 5;

  localparam int PIN_POL_LSB   = 8;
  localparam int CLR_CMP_LSB   = 8;
  localparam int CLR_LATCH_BIT = 16;
endpackage

// File: rtl/fault_pin_sync.sv
module fault_pin_sync #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] pin_sync_o
);
  for (genvar i = 0; i < NP; i++) begin : g_pin
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
      end
    end
    assign pin_sync_o[i] = s2_q;
  end
endmodule

// File: rtl/pwm_fault_regs.sv
module pwm_fault_regs
  import pwm_fault_pkg::*;
#(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          latch_mode,
  output logic          stretch_en,
  output logic          stall_en,
  output logic          irq_en,
  output logic          safe_a,
  output logic          safe_b,
  output logic [NP-1:0] pin_en,
  output logic [NP-1:0] pin_pol,
  output logic [NC-1:0] cmp_en,
  output logic [CW-1:0] min_per,
  output logic [NP-1:0] clr_pin,
  output logic [NC-1:0] clr_cmp,
  output logic          clr_latch
);
  logic sel_cfg, sel_pins, sel_cmp, sel_min, sel_clr;

  assign sel_cfg  = wr_en && (wr_addr == AW'(REG_CFG));
  assign sel_pins = wr_en && (wr_addr == AW'(REG_PINS));
  assign sel_cmp  = wr_en && (wr_addr == AW'(REG_CMP));
  assign sel_min  = wr_en && (wr_addr == AW'(REG_MINPER));
  assign sel_clr  = wr_en && (wr_addr == AW'(REG_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_mode <= 1'b0;
      stretch_en <= 1'b0;
      stall_en   <= 1'b0;
      irq_en     <= 1'b0;
      safe_a     <= 1'b0;
      safe_b     <= 1'b0;
      pin_en     <= '0;
      pin_pol    <= '0;
      cmp_en     <= '0;
      min_per    <= '0;
    end else begin
      if (sel_cfg) begin
        latch_mode <= wr_data[CFG_LATCH];
        stretch_en <= wr_data[CFG_STRETCH];
        stall_en   <= wr_data[CFG_STALL];
        irq_en     <= wr_data[CFG_IRQ];
        safe_a     <= wr_data[CFG_SAFE_A];
        safe_b     <= wr_data[CFG_SAFE_B];
      end
      if (sel_pins) begin
        pin_en  <= wr_data[NP-1:0];
        pin_pol <= wr_data[PIN_POL_LSB +: NP];
      end
      if (sel_cmp) cmp_en  <= wr_data[NC-1:0];
      if (sel_min) min_per <= wr_data[CW-1:0];
    end
  end

  assign clr_pin   = sel_clr ? wr_data[NP-1:0] : '0;
  assign clr_cmp   = sel_clr ? wr_data[CLR_CMP_LSB +: NC] : '0;
  assign clr_latch = sel_clr && wr_data[CLR_LATCH_BIT];

  logic unused_data_bits;
  assign unused_data_bits = ^wr_data[DW-1:CLR_LATCH_BIT+1];
endmodule

// File: rtl/fault_stretch.sv
module fault_stretch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_cond,
  input  logic          stretch_en,
  input  logic [CW-1:0] min_per,
  output logic [CW-1:0] cnt_q,
  output logic          fault_cond
);
  function automatic logic [CW-1:0] next_count(input logic hit,
                                               input logic [CW-1:0] reload,
                                               input logic [CW-1:0] cur);
    if (hit)             return reload;
    else if (cur != '0)  return cur - 1'b1;
    else                 return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(raw_cond, min_per, cnt_q);
  end

  assign fault_cond = raw_cond | (stretch_en & (cnt_q != '0));
endmodule

// File: rtl/fault_latch_status.sv
module fault_latch_status #(
  parameter int NP = 4,
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_cond,
  input  logic          latch_mode,
  input  logic          clr_latch,
  input  logic [NP-1:0] pin_hit,
  input  logic [NC-1:0] cmp_hit,
  input  logic [NP-1:0] clr_pin,
  input  logic [NC-1:0] clr_cmp,
  output logic          latched_q,
  output logic          fault_act,
  output logic [NP-1:0] pin_stat,
  output logic [NC-1:0] cmp_stat
);
  function automatic logic [NC-1:0] sticky_next(input logic [NC-1:0] cur,
                                                input logic [NC-1:0] set,
                                                input logic [NC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  logic [NC-1:0] pin_next_w;
  assign pin_next_w = sticky_next(NC'(pin_stat), NC'(pin_hit), NC'(clr_pin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      pin_stat  <= '0;
      cmp_stat  <= '0;
    end else begin
      if (!latch_mode)                 latched_q <= 1'b0;
      else if (fault_cond)             latched_q <= 1'b1;
      else if (clr_latch)              latched_q <= 1'b0;
      pin_stat <= pin_next_w[NP-1:0];
      cmp_stat <= sticky_next(cmp_stat, cmp_hit, clr_cmp);
    end
  end

  assign fault_act = fault_cond | (latch_mode & latched_q);

  logic unused_pin_bits;
  assign unused_pin_bits = (NC > NP) ? ^pin_next_w : 1'b0;
endmodule

// File: rtl/pwm_fault_unit.sv
module pwm_fault_unit #(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [NP-1:0] fault_pin_i,
  input  logic          dbg_stall_i,
  input  logic [NC-1:0] cmp_trig_i,
  input  logic          pwm_a_i,
  input  logic          pwm_b_i,
  output logic          pwm_a_o,
  output logic          pwm_b_o,
  output logic          fault_o,
  output logic          irq_o,
  output logic [NP-1:0] pin_stat_o,
  output logic [NC-1:0] cmp_stat_o
);
  logic          latch_mode, stretch_en, stall_en, irq_en, safe_a, safe_b;
  logic [NP-1:0] pin_en, pin_pol, clr_pin, pin_sync, pin_hit;
  logic [NC-1:0] cmp_en, clr_cmp, cmp_hit;
  logic [CW-1:0] min_per, cnt_q;
  logic          clr_latch, raw_cond, fault_cond, latched_q, fault_act;

  pwm_fault_regs #(.NP(NP), .NC(NC), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .latch_mode(latch_mode), .stretch_en(stretch_en), .stall_en(stall_en),
    .irq_en(irq_en), .safe_a(safe_a), .safe_b(safe_b), .pin_en(pin_en),
    .pin_pol(pin_pol), .cmp_en(cmp_en), .min_per(min_per),
    .clr_pin(clr_pin), .clr_cmp(clr_cmp), .clr_latch(clr_latch)
  );

  fault_pin_sync #(.NP(NP)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(fault_pin_i), .pin_sync_o(pin_sync)
  );

  // polarity correction then per-source enable
  assign pin_hit  = (pin_sync ^ pin_pol) & pin_en;
  assign cmp_hit  = cmp_trig_i & cmp_en;
  assign raw_cond = (|pin_hit) | (|cmp_hit) | (dbg_stall_i & stall_en);

  fault_stretch #(.CW(CW)) u_stretch (
    .clk(clk), .rst_n(rst_n), .raw_cond(raw_cond), .stretch_en(stretch_en),
    .min_per(min_per), .cnt_q(cnt_q), .fault_cond(fault_cond)
  );

  fault_latch_status #(.NP(NP), .NC(NC)) u_latch (
    .clk(clk), .rst_n(rst_n), .fault_cond(fault_cond), .latch_mode(latch_mode),
    .clr_latch(clr_latch), .pin_hit(pin_hit), .cmp_hit(cmp_hit),
    .clr_pin(clr_pin), .clr_cmp(clr_cmp), .latched_q(latched_q),
    .fault_act(fault_act), .pin_stat(pin_stat_o), .cmp_stat(cmp_stat_o)
  );

  assign fault_o = fault_act;
  assign irq_o   = fault_act & irq_en;
  assign pwm_a_o = fault_act ? safe_a : pwm_a_i;
  assign pwm_b_o = fault_act ? safe_b : pwm_b_i;
endmodule

// File: rtl/pwm_fault_unit_chk.sv
module pwm_fault_unit_chk #(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] fault_pin_i,
  input logic [NP-1:0] pin_sync,
  input logic          raw_cond,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] min_per,
  input logic          stretch_en,
  input logic          fault_cond,
  input logic          latch_mode,
  input logic          latched_q,
  input logic          clr_latch,
  input logic [NP-1:0] pin_hit,
  input logic [NC-1:0] cmp_hit,
  input logic [NP-1:0] pin_stat_o,
  input logic [NC-1:0] cmp_stat_o,
  input logic          irq_o,
  input logic          fault_o,
  input logic          pwm_a_o,
  input logic          pwm_b_o,
  input logic          safe_a,
  input logic          safe_b
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (pin_sync == $past(fault_pin_i, 2)));

  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !stretch_en) |-> (fault_o == raw_cond));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && latched_q && !clr_latch) |=> latched_q);

  assert_clear_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && fault_cond && clr_latch) |=> latched_q);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_cond |=> (cnt_q == $past(min_per)));

  assert_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_cond) && stretch_en && $past(stretch_en) && $past(min_per) != '0)
      |-> fault_cond);

  assert_pin_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_stat_o & $past(pin_hit)) == $past(pin_hit)));

  assert_cmp_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cmp_stat_o & $past(cmp_hit)) == $past(cmp_hit)));

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> fault_o);

  assert_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (pwm_a_o == safe_a && pwm_b_o == safe_b));
endmodule

bind pwm_fault_unit pwm_fault_unit_chk #(.NP(NP), .NC(NC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_pin_i(fault_pin_i), .pin_sync(pin_sync),
  .raw_cond(raw_cond), .cnt_q(cnt_q), .min_per(min_per), .stretch_en(stretch_en),
  .fault_cond(fault_cond), .latch_mode(latch_mode), .latched_q(latched_q),
  .clr_latch(clr_latch), .pin_hit(pin_hit), .cmp_hit(cmp_hit),
  .pin_stat_o(pin_stat_o), .cmp_stat_o(cmp_stat_o), .irq_o(irq_o),
  .fault_o(fault_o), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o),
  .safe_a(safe_a), .safe_b(safe_b)
);

// File: tb/pwm_fault_unit_tb.sv
module pwm_fault_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  fault_pin_i = '0;
  logic        dbg_stall_i = 1'b0;
  logic [7:0]  cmp_trig_i = '0;
  logic        pwm_a_i = 1'b0, pwm_b_i = 1'b0;
  logic        pwm_a_o, pwm_b_o, fault_o, irq_o;
  logic [3:0]  pin_stat_o;
  logic [7:0]  cmp_stat_o;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .fault_pin_i(fault_pin_i), .dbg_stall_i(dbg_stall_i),
    .cmp_trig_i(cmp_trig_i), .pwm_a_i(pwm_a_i), .pwm_b_i(pwm_b_i),
    .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .fault_o(fault_o), .irq_o(irq_o),
    .pin_stat_o(pin_stat_o), .cmp_stat_o(cmp_stat_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // write on one posedge; returns at the following negedge with the value applied
  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'(addr); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    pwm_a_i = 1'b1; pwm_b_i = 1'b0;
    #1;
    chk("R11 fault", {31'd0, fault_o}, 32'd0);
    chk("R11 irq", {31'd0, irq_o}, 32'd0);
    chk("R11 status", {20'd0, cmp_stat_o, pin_stat_o}, 32'd0);
    chk("R11 passthrough", {30'd0, pwm_a_o, pwm_b_o}, 32'd2);
  endtask

  task automatic t_sync_polarity;
    wr(1, 32'h0000_0001);              // pin0 enabled, active high
    fault_pin_i = 4'b0001;
    @(negedge clk);
    chk("R1 one edge", {31'd0, fault_o}, 32'd0);
    @(negedge clk);
    chk("R1 two edges", {31'd0, fault_o}, 32'd1);
    wr(1, 32'h0000_0101);              // pin0 active low, pin held high
    chk("R2 active-low high level", {31'd0, fault_o}, 32'd0);
    fault_pin_i = 4'b0000;
    step(2);
    chk("R2 active-low low level", {31'd0, fault_o}, 32'd1);
    wr(1, 32'h0);
    fault_pin_i = 4'b0000;
    wr(4, 32'h0000_FFFF);
  endtask

  task automatic t_enables;
    fault_pin_i = 4'b1111;
    step(3);
    chk("R3 pins disabled", {31'd0, fault_o}, 32'd0);
    fault_pin_i = 4'b0000;
    wr(2, 32'h0000_0020);
    cmp_trig_i = 8'h04;
    #1 chk("R3 cmp line not enabled", {31'd0, fault_o}, 32'd0);
    cmp_trig_i = 8'h20;
    #1 chk("R3 cmp line enabled", {31'd0, fault_o}, 32'd1);
    cmp_trig_i = 8'h00;
    #1 chk("R4 follow drop", {31'd0, fault_o}, 32'd0);
    dbg_stall_i = 1'b1;
    #1 chk("R3 stall disabled", {31'd0, fault_o}, 32'd0);
    wr(0, 32'h0000_0004);
    chk("R3 stall enabled", {31'd0, fault_o}, 32'd1);
    dbg_stall_i = 1'b0;
    #1 chk("R4 stall drop", {31'd0, fault_o}, 32'd0);
    wr(0, 32'h0);
    wr(4, 32'h0000_FFFF);
  endtask

  task automatic t_stretch;
    wr(3, 32'd3);
    wr(0, 32'h0000_0002);
    @(negedge clk); cmp_trig_i = 8'h20;
    @(negedge clk); cmp_trig_i = 8'h00;
    #1 chk("R6 tail cycle 1", {31'd0, fault_o}, 32'd1);
    step(2);
    chk("R6 tail cycle 3", {31'd0, fault_o}, 32'd1);
    step(1);
    chk("R6 tail ends", {31'd0, fault_o}, 32'd0);
    wr(0, 32'h0);
    @(negedge clk); cmp_trig_i = 8'h20;
    @(negedge clk); cmp_trig_i = 8'h00;
    #1 chk("R7 no tail", {31'd0, fault_o}, 32'd0);
    wr(4, 32'h0000_FFFF);
  endtask

  task automatic t_latch;
    wr(0, 32'h0000_0001);
    @(negedge clk); cmp_trig_i = 8'h20;
    @(negedge clk); cmp_trig_i = 8'h00;
    step(2);
    chk("R5 held after drop", {31'd0, fault_o}, 32'd1);
    cmp_trig_i = 8'h20;
    wr(4, 32'h0001_0000);              // clear while condition present
    cmp_trig_i = 8'h00;
    #1 chk("R5 clear ignored", {31'd0, fault_o}, 32'd1);
    wr(4, 32'h0001_0000);
    chk("R5 clear accepted", {31'd0, fault_o}, 32'd0);
    wr(0, 32'h0);
    wr(4, 32'h0000_FFFF);
  endtask

  task automatic t_status;
    @(negedge clk); cmp_trig_i = 8'h20;
    @(negedge clk); cmp_trig_i = 8'h00;
    chk("R8 cmp set", {24'd0, cmp_stat_o}, 32'h20);
    wr(4, 32'h0000_0100);              // clears cmp bit0 only
    chk("R8 other clear no effect", {24'd0, cmp_stat_o}, 32'h20);
    wr(4, 32'h0000_2000);
    chk("R8 cmp cleared", {24'd0, cmp_stat_o}, 32'h00);
    cmp_trig_i = 8'h20;
    wr(4, 32'h0000_2000);              // set and clear in same cycle
    cmp_trig_i = 8'h00;
    @(negedge clk);
    chk("R8 set beats clear", {24'd0, cmp_stat_o}, 32'h20);
    wr(1, 32'h0000_0004);
    fault_pin_i = 4'b0100;
    step(3);
    fault_pin_i = 4'b0000;
    step(3);
    chk("R8 pin sticky", {28'd0, pin_stat_o}, 32'h4);
    wr(4, 32'h0000_0004);
    chk("R8 pin cleared", {28'd0, pin_stat_o}, 32'h0);
    wr(1, 32'h0);
    wr(4, 32'h0000_FFFF);
  endtask

  task automatic t_irq_safe;
    pwm_a_i = 1'b0; pwm_b_i = 1'b1;
    wr(0, 32'h0000_0010);              // safe A=1, B=0, irq off
    cmp_trig_i = 8'h20;
    #1 chk("R9 irq disabled", {31'd0, irq_o}, 32'd0);
    chk("R10 safe levels", {30'd0, pwm_a_o, pwm_b_o}, 32'd2);
    cmp_trig_i = 8'h00;
    #1 chk("R10 passthrough", {30'd0, pwm_a_o, pwm_b_o}, 32'd1);
    wr(0, 32'h0000_0028);              // irq on, safe B=1, A=0
    cmp_trig_i = 8'h20;
    #1 chk("R9 irq enabled", {31'd0, irq_o}, 32'd1);
    chk("R10 safe levels alt", {30'd0, pwm_a_o, pwm_b_o}, 32'd1);
    cmp_trig_i = 8'h00;
    #1 chk("R9 irq drops", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sync_polarity();
    t_enables();
    t_stretch();
    t_latch();
    t_status();
    t_irq_safe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule